// File: doc/BRIEF.md
# DSP Status Register Bit Control

This block holds the 16-bit status register of a DSP core and updates it from two instruction families. The bit-set and bit-clear instructions carry a 3-bit immediate. The bit they act on is that immediate plus a fixed offset of 6, so they reach bits 6 through 13. The mode-control family uses a 4-bit selector nibble. Each selector value either clears or sets one named mode bit, and the values come in clear/set pairs.

Three of the mode bits drive other units and also appear on separate output pins:
- the multiplier-doubling bit, which lets the multiplier scale its product by two at no cost;
- the unsigned-multiply bit, which makes multiplicands unsigned when set and signed when clear;
- the 40-bit accumulator bit, which selects 40-bit accumulator behaviour when set and 16-bit behaviour when clear.

The instruction word arrives with a valid strobe. The register changes on the clock edge that samples a valid instruction. Bits 0 through 5 are not reachable by any instruction handled here, so they stay zero.

Top module: `sr_bitctl`

## Requirements
- R1: A synchronous active-high reset clears the whole status register and the three mode outputs to zero.
- R2: A valid word with bits 15:8 equal to 0x12 sets status bit (bits 2:0 + 6). Bits 7:3 of the word are ignored, and every other status bit keeps its value.
- R3: A valid word with bits 15:8 equal to 0x13 clears status bit (bits 2:0 + 6). Bits 7:3 of the word are ignored, and every other status bit keeps its value.
- R4: A valid word with bits 15:12 equal to 0x8 is a mode word. Selector bits 11:8 = 0xA clear the multiplier-doubling bit, which is status bit 13. Selector 0xB sets it.
- R5: In a mode word, selector 0xC clears the unsigned-multiply bit, which is status bit 15. Selector 0xD sets it.
- R6: In a mode word, selector 0xE clears the 40-bit mode bit, which is status bit 14. Selector 0xF sets it.
- R7: A mode word with selector 0x0 through 0x9 leaves the status register unchanged.
- R8: The status register holds its value when the valid strobe is low, whatever the word. It also holds its value when the strobe is high and the word belongs to neither family.
- R9: An update is visible only after the clock edge that samples the valid word. The outputs mul_double_o, acc40_o and mul_unsigned_o always equal status bits 13, 14 and 15.
- R10: A set or clear instruction with immediate 7 acts on bit 13. That is the multiplier-doubling bit, so the instruction changes mul_double_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Qualifies insn_word for one cycle |
| insn_word | input | 16 | Instruction word |
| status_o | output | 16 | Current status register |
| mul_double_o | output | 1 | Multiplier-doubling mode bit (status bit 13) |
| acc40_o | output | 1 | 40-bit accumulator mode bit (status bit 14) |
| mul_unsigned_o | output | 1 | Unsigned-multiply bit (status bit 15) |

## Verification
The sweeps aim at the offset arithmetic. A decoder that drops the +6, or wraps it, would move the set or clear onto bits 0 through 5, and the full-word compare catches it. The sweeps also check that the low immediate bits are decoded and the middle bits ignored. Every selector nibble is tried from both the all-clear and the all-set register state. This exposes swapped clear/set pairs, a wrong bit position for one mode bit, and any update on selectors 0 through 9. Further runs exercise a low strobe, foreign opcodes, and the overlap between immediate 7 and the doubling bit; a design that pipelined or ignored the strobe, or kept a private copy of a mode bit, would disagree with the model in the first cycle after the edge.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int INSN_W = 16;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_BSET = 2'd1,
    CLS_BCLR = 2'd2,
    CLS_MODE = 2'd3
  } insn_cls_e;

  localparam logic [7:0] OPC_BSET  = 8'h12;
  localparam logic [7:0] OPC_BCLR  = 8'h13;
  localparam logic [3:0] GRP_MODE  = 4'h8;

  localparam logic [3:0] SEL_DBL_CLR = 4'hA;
  localparam logic [3:0] SEL_DBL_SET = 4'hB;
  localparam logic [3:0] SEL_UNS_CLR = 4'hC;
  localparam logic [3:0] SEL_UNS_SET = 4'hD;
  localparam logic [3:0] SEL_A40_CLR = 4'hE;
  localparam logic [3:0] SEL_A40_SET = 4'hF;
endpackage

// File: rtl/sr_decode.sv
module sr_decode
  import sr_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int IMM_W     = 3,
  parameter int BIT_OFS   = 6,
  parameter int DBL_POS   = 13,
  parameter int A40_POS   = 14,
  parameter int UNS_POS   = 15
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] word,
  output logic [SR_W-1:0]   set_mask,
  output logic [SR_W-1:0]   clr_mask
);
  localparam int IDX_W = $clog2(SR_W);

  insn_cls_e        cls;
  logic [IDX_W-1:0] tgt_idx;
  logic [SR_W-1:0]  mode_set;
  logic [SR_W-1:0]  mode_clr;

  always_comb begin
    cls = CLS_NONE;
    if (valid) begin
      if (word[15:8] == OPC_BSET)       cls = CLS_BSET;
      else if (word[15:8] == OPC_BCLR)  cls = CLS_BCLR;
      else if (word[15:12] == GRP_MODE) cls = CLS_MODE;
    end
  end

  assign tgt_idx = IDX_W'(word[IMM_W-1:0]) + IDX_W'(BIT_OFS);

  always_comb begin
    mode_set = '0;
    mode_clr = '0;
    if (cls == CLS_MODE) begin
      case (word[11:8])
        SEL_DBL_CLR: mode_clr[DBL_POS] = 1'b1;
        SEL_DBL_SET: mode_set[DBL_POS] = 1'b1;
        SEL_UNS_CLR: mode_clr[UNS_POS] = 1'b1;
        SEL_UNS_SET: mode_set[UNS_POS] = 1'b1;
        SEL_A40_CLR: mode_clr[A40_POS] = 1'b1;
        SEL_A40_SET: mode_set[A40_POS] = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < SR_W; b++) begin : g_mask
    logic hit;
    assign hit         = (tgt_idx == IDX_W'(b));
    assign set_mask[b] = ((cls == CLS_BSET) && hit) || mode_set[b];
    assign clr_mask[b] = ((cls == CLS_BCLR) && hit) || mode_clr[b];
  end
endmodule

// File: rtl/sr_update.sv
module sr_update #(
  parameter int SR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SR_W-1:0] set_mask,
  input  logic [SR_W-1:0] clr_mask,
  output logic [SR_W-1:0] sr_q
);
  logic [SR_W-1:0] sr_d;

  assign sr_d = (sr_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= sr_d;
  end
endmodule

// File: rtl/sr_bitctl.sv
module sr_bitctl
  import sr_pkg::*;
#(
  parameter int SR_W    = 16,
  parameter int IMM_W   = 3,
  parameter int BIT_OFS = 6,
  parameter int DBL_POS = 13,
  parameter int A40_POS = 14,
  parameter int UNS_POS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [INSN_W-1:0] insn_word,
  output logic [SR_W-1:0]   status_o,
  output logic              mul_double_o,
  output logic              acc40_o,
  output logic              mul_unsigned_o
);
  logic [SR_W-1:0] set_mask;
  logic [SR_W-1:0] clr_mask;
  logic [SR_W-1:0] sr_q;

  sr_decode #(
    .SR_W(SR_W), .IMM_W(IMM_W), .BIT_OFS(BIT_OFS),
    .DBL_POS(DBL_POS), .A40_POS(A40_POS), .UNS_POS(UNS_POS)
  ) u_dec (
    .valid    (insn_valid),
    .word     (insn_word),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  sr_update #(.SR_W(SR_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .sr_q     (sr_q)
  );

  assign status_o       = sr_q;
  assign mul_double_o   = sr_q[DBL_POS];
  assign acc40_o        = sr_q[A40_POS];
  assign mul_unsigned_o = sr_q[UNS_POS];
endmodule

// File: rtl/sr_bitctl_chk.sv
module sr_bitctl_chk #(
  parameter int SR_W    = 16,
  parameter int IMM_W   = 3,
  parameter int BIT_OFS = 6,
  parameter int DBL_POS = 13,
  parameter int A40_POS = 14,
  parameter int UNS_POS = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            insn_valid,
  input logic [15:0]     insn_word,
  input logic [SR_W-1:0] status_o,
  input logic            mul_double_o,
  input logic            acc40_o,
  input logic            mul_unsigned_o,
  input logic [SR_W-1:0] set_mask,
  input logic [SR_W-1:0] clr_mask
);
  logic            pv;
  logic [15:0]     pw;
  logic [SR_W-1:0] ps;
  logic            prst;
  int              pidx;

  always_ff @(posedge clk) begin
    pv   <= insn_valid && !rst;
    pw   <= insn_word;
    ps   <= status_o;
    prst <= rst;
  end

  assign pidx = int'(pw[IMM_W-1:0]) + BIT_OFS;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status_o == '0)); // R1

  AST_SET_HITS: assert property (@(posedge clk) disable iff (rst || prst)
    (pv && pw[15:8] == 8'h12) |-> (status_o[pidx] == 1'b1)); // R2

  AST_CLR_HITS: assert property (@(posedge clk) disable iff (rst || prst)
    (pv && pw[15:8] == 8'h13) |-> (status_o[pidx] == 1'b0)); // R3

  AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (rst || prst)
    $countones(status_o ^ ps) <= 1); // R2

  AST_DBL_SET: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[15:12] == 4'h8 && insn_word[11:8] == 4'hB) |=> mul_double_o); // R4

  AST_UNS_CLR: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[15:12] == 4'h8 && insn_word[11:8] == 4'hC) |=> !mul_unsigned_o); // R5

  AST_A40_SET: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[15:12] == 4'h8 && insn_word[11:8] == 4'hF) |=> acc40_o); // R6

  AST_MODE_NOP: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[15:12] == 4'h8 && insn_word[11:8] < 4'hA) |=> $stable(status_o)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> $stable(status_o)); // R8

  AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (set_mask & clr_mask) == '0); // R9

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[BIT_OFS-1:0] == '0); // R2
endmodule

bind sr_bitctl sr_bitctl_chk #(
  .SR_W(SR_W), .IMM_W(IMM_W), .BIT_OFS(BIT_OFS),
  .DBL_POS(DBL_POS), .A40_POS(A40_POS), .UNS_POS(UNS_POS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .insn_valid     (insn_valid),
  .insn_word      (insn_word),
  .status_o       (status_o),
  .mul_double_o   (mul_double_o),
  .acc40_o        (acc40_o),
  .mul_unsigned_o (mul_unsigned_o),
  .set_mask       (set_mask),
  .clr_mask       (clr_mask)
);

// File: tb/test_sr_bitctl.sv
module test_sr_bitctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [15:0] insn_word = 16'h0000;
  logic [15:0] status_o;
  logic        mul_double_o, acc40_o, mul_unsigned_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_sr = 16'h0000;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  sr_bitctl i_sr_bitctl (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .status_o(status_o), .mul_double_o(mul_double_o),
    .acc40_o(acc40_o), .mul_unsigned_o(mul_unsigned_o)
  );

  function automatic logic [15:0] model(logic [15:0] cur, logic [15:0] w, logic v);
    logic [15:0] n = cur;
    int idx = int'(w[2:0]) + 6;
    if (!v) return n;
    if (w[15:8] == 8'h12)      n[idx] = 1'b1;
    else if (w[15:8] == 8'h13) n[idx] = 1'b0;
    else if (w[15:12] == 4'h8) begin
      case (w[11:8])
        4'hA: n[13] = 1'b0;
        4'hB: n[13] = 1'b1;
        4'hC: n[15] = 1'b0;
        4'hD: n[15] = 1'b1;
        4'hE: n[14] = 1'b0;
        4'hF: n[14] = 1'b1;
        default: ;
      endcase
    end
    return n;
  endfunction

  function automatic string tag_of(logic [15:0] w, logic v);
    if (!v) return "R8";
    if (w[15:8] == 8'h12) return (w[2:0] == 3'd7) ? "R10" : "R2";
    if (w[15:8] == 8'h13) return (w[2:0] == 3'd7) ? "R10" : "R3";
    if (w[15:12] == 4'h8) begin
      case (w[11:8])
        4'hA, 4'hB: return "R4";
        4'hC, 4'hD: return "R5";
        4'hE, 4'hF: return "R6";
        default:    return "R7";
      endcase
    end
    return "R8";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    check(req, status_o, exp_sr);
    check("R9", {13'd0, mul_unsigned_o, acc40_o, mul_double_o},
          {13'd0, exp_sr[15], exp_sr[14], exp_sr[13]});
  endtask

  task automatic step(logic [15:0] w, logic v);
    @(negedge clk);
    insn_word  = w;
    insn_valid = v;
    #2;
    check("R9", status_o, exp_sr);
    exp_sr = model(exp_sr, w, v);
    @(negedge clk);
    insn_valid = 1'b0;
    check_outs(tag_of(w, v));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_sr = 16'h0000;
    check_outs("R1");
  endtask

  initial begin
    #4_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R2 / R3: every immediate with several values in the ignored bits 7:3
    for (int j = 0; j < 32; j += 7) begin
      for (int i = 0; i < 8; i++) step({8'h12, 5'(j), 3'(i)}, 1'b1);
      for (int i = 0; i < 8; i++) step({8'h13, 5'(j), 3'(i)}, 1'b1);
    end
    // R2 / R3: single bits from empty and full states
    for (int i = 0; i < 8; i++) begin
      step({8'h12, 5'd0, 3'(i)}, 1'b1);
      step({8'h13, 5'd31, 3'(i)}, 1'b1);
    end

    // R4..R7: every selector from all-clear and from all-set mode bits
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 16; s++) begin
        step(16'h8A00 | {4'h0, (k == 0) ? 4'h0 : 4'h0, 8'h00}, 1'b1);
        step(16'h8C00, 1'b1);
        step(16'h8E00, 1'b1);
        if (k == 1) begin
          step(16'h8B00, 1'b1);
          step(16'h8D00, 1'b1);
          step(16'h8F00, 1'b1);
        end
        step({4'h8, 4'(s), 8'(s * 17)}, 1'b1);
      end
    end

    // R8: strobe low with every kind of word, and foreign opcodes
    for (int i = 0; i < 8; i++) step({8'h12, 5'd0, 3'(i)}, 1'b0);
    step(16'h8B00, 1'b0);
    step(16'h8D00, 1'b0);
    step(16'h1400, 1'b1);
    step(16'h1100, 1'b1);
    step(16'h0312, 1'b1);
    step(16'h9F00, 1'b1);

    // R10: immediate 7 reaches the doubling bit
    step(16'h8A00, 1'b1);
    step(16'h1207, 1'b1);
    check("R10", {15'd0, mul_double_o}, 16'h0001);
    step(16'h8B00, 1'b1);
    step(16'h13FF, 1'b1);
    check("R10", {15'd0, mul_double_o}, 16'h0000);

    // mixed stream with random strobe
    for (int n = 0; n < 600; n++) begin
      logic [15:0] w;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (lcg[31:30])
        2'd0: w = {8'h12, lcg[20:13]};
        2'd1: w = {8'h13, lcg[20:13]};
        2'd2: w = {4'h8, lcg[19:8]};
        default: w = lcg[23:8];
      endcase
      step(w, lcg[5] | lcg[6]);
    end

    // R1: reset from a loaded state
    step(16'h8F00, 1'b1);
    step(16'h8D00, 1'b1);
    step(16'h1203, 1'b1);
    do_reset();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule